// File: doc/BRIEF.md
# Variable-Latency Multiplier with Hold Prediction and Shadow Check

This block multiplies two unsigned `W`-bit operands and returns the `2W`-bit product. The time spent on each product is chosen per operation. A hold predictor examines the multiplicand while the operands are accepted, and it runs alongside the array. The predictor counts the zero bits of the multiplicand. With many zeros, most rows of the bypassing array are skipped, so the product is sampled one clock after launch. With few zeros, the sample is taken after two clocks, and input acceptance stalls for the extra cycle.

Every product bit is sampled twice. The main sample is taken at the end of the allotted window. A shadow sample, standing in for a delayed clock, is taken one cycle later. If the two samples disagree, the window was too short for that operand pair. The block then pulses an error, discards the main sample and re-executes the same operation with a two-cycle window. Only one product beat leaves the block for each accepted pair.

The array's settling time is modelled deterministically. A multiplicand with fewer than `AGED_ZEROS` zero bits needs two cycles to settle; any other multiplicand needs one. Raising `AGED_ZEROS` above `ZERO_THRESH` therefore injects timing violations on chosen operands. Three counters report the completed products, the operations predicted to need two cycles, and the replays.

Top module: `mulvl_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` and `replay_err` are 0, and all three counters read 0.
- R2: Each output beat carries the unsigned product `op_a * op_b` of one accepted pair, in `2W` bits. Beats leave in acceptance order.
- R3: The multiplicand `op_a` has a zero-bit count Z. If Z is greater than or equal to `ZERO_THRESH` (default `W/2`), the operation is predicted to need one cycle. If the pair is accepted at edge E, the beat (or a replay error) is visible after edge E+2.
- R4: If Z is less than `ZERO_THRESH`, the operation is predicted to need two cycles. If the pair is accepted at edge E, the beat is visible after edge E+3, and such an operation never raises `replay_err`.
- R5: After a pair is accepted, `in_ready` is 0 in the next cycle. A new pair can be accepted in the same cycle that the previous product commits, so one-cycle operations can be accepted every 2 cycles and two-cycle operations every 3 cycles.
- R6: A one-cycle operation whose multiplicand has fewer than `AGED_ZEROS` zero bits fails the shadow comparison. For a pair accepted at edge E, `replay_err` pulses for one cycle after edge E+2, and the correct beat is visible after edge E+5.
- R7: `out_valid` and `replay_err` are never 1 in the same cycle. A replay produces no extra beat, so exactly one beat is emitted per accepted pair.
- R8: `cnt_done` counts beats and `cnt_replay` counts `replay_err` pulses. `cnt_long` counts accepted pairs predicted to need two cycles (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pair accepted this cycle when both are 1 |
| op_a | input | W | Multiplicand; its zero bits set the latency |
| op_b | input | W | Multiplier |
| out_valid | output | 1 | One-cycle product beat |
| out_prod | output | 2W | Product, valid with `out_valid` |
| replay_err | output | 1 | One-cycle pulse: shadow mismatch, operation being redone |
| cnt_done | output | CNT_W | Completed products |
| cnt_long | output | CNT_W | Operations predicted to need two cycles |
| cnt_replay | output | CNT_W | Replays after a shadow mismatch |

## Verification
The assertions assume that the operands stay stable only in the cycle they are accepted. They also assume that the settling model never needs more than two cycles, which holds for the single `AGED_ZEROS` rule. The latency properties count cycles from acceptance, so they allow a beat from the previous operation to appear in the cycle right after a new pair is accepted. The stimulus drives operands on falling edges and drops `in_valid` for the busy cycle after each acceptance. It also picks multiplicands with zero counts below, between and above the two thresholds, so that every latency path is reached, both back-to-back and with idle gaps.

// File: rtl/mulvl_pkg.sv
package mulvl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SHADOW = 2'd2
  } mulvl_state_e;

  localparam int MAX_W = 32;

  // Number of zero bits among the low w bits of a.
  function automatic int zero_count(input logic [MAX_W-1:0] a, input int w);
    int z;
    z = 0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < w && !a[i]) z++;
    end
    return z;
  endfunction

  // Row-bypassing product: rows whose multiplicand bit is zero add nothing.
  function automatic logic [2*MAX_W-1:0] bypass_mul(input logic [MAX_W-1:0] a,
                                                    input logic [MAX_W-1:0] b,
                                                    input int w);
    logic [2*MAX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < w && a[i]) acc = acc + ({{MAX_W{1'b0}}, b} << i);
    end
    return acc;
  endfunction

  // Cycles the array needs to settle for a given multiplicand.
  function automatic int settle_need(input int zeros, input int aged_zeros);
    return (zeros >= aged_zeros) ? 1 : 2;
  endfunction

endpackage

// File: rtl/mulvl_hold.sv
module mulvl_hold #(
  parameter int W           = 8,
  parameter int ZERO_THRESH = W / 2
) (
  input  logic [W-1:0] mcand,
  output logic         one_cycle
);
  import mulvl_pkg::*;

  logic [MAX_W-1:0] mcand_ext;
  int               zeros;

  always_comb begin
    mcand_ext = '0;
    mcand_ext[W-1:0] = mcand;
    zeros = zero_count(mcand_ext, W);
    one_cycle = (zeros >= ZERO_THRESH);
  end
endmodule

// File: rtl/mulvl_core.sv
module mulvl_core #(
  parameter int W          = 8,
  parameter int AGED_ZEROS = W / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic           restart,
  input  logic [W-1:0]   launch_a,
  input  logic [W-1:0]   launch_b,
  output logic [W-1:0]   opa_q,
  output logic [W-1:0]   opb_q,
  output logic [1:0]     age_q,
  output logic [2*W-1:0] core_p
);
  import mulvl_pkg::*;

  localparam int P = 2 * W;

  logic [MAX_W-1:0]   a_ext, b_ext;
  logic [2*MAX_W-1:0] full_p;
  logic [P-1:0]       exact_p;
  logic               settled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
      age_q <= '0;
    end else if (launch) begin
      opa_q <= launch_a;
      opb_q <= launch_b;
      age_q <= '0;
    end else if (restart) begin
      age_q <= '0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    a_ext = '0;
    b_ext = '0;
    a_ext[W-1:0] = opa_q;
    b_ext[W-1:0] = opb_q;
    full_p  = bypass_mul(a_ext, b_ext, W);
    exact_p = full_p[P-1:0];
    // A sample at the end of the age_q cycle has seen age_q+1 cycles.
    settled = (int'(age_q) + 1) >= settle_need(zero_count(a_ext, W), AGED_ZEROS);
    core_p  = settled ? exact_p : ~exact_p;
  end
endmodule

// File: rtl/mulvl_razor.sv
module mulvl_razor #(
  parameter int P = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_main,
  input  logic [P-1:0] core_p,
  output logic [P-1:0] main_q,
  output logic [P-1:0] shadow_d,
  output logic         match
);
  genvar gi;
  generate
    for (gi = 0; gi < P; gi++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)        main_q[gi] <= 1'b0;
        else if (cap_main) main_q[gi] <= core_p[gi];
      end
    end
  endgenerate

  // The shadow sample is the array output one cycle after the main capture.
  assign shadow_d = core_p;
  assign match    = (main_q == shadow_d);
endmodule

// File: rtl/mulvl_top.sv
module mulvl_top #(
  parameter int W           = 8,
  parameter int ZERO_THRESH = W / 2,
  parameter int AGED_ZEROS  = W / 2,
  parameter int CNT_W       = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_prod,
  output logic           replay_err,
  output logic [CNT_W-1:0] cnt_done,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_replay
);
  import mulvl_pkg::*;

  localparam int P = 2 * W;

  mulvl_state_e state_q;
  logic         two_q;
  logic         hold_one;
  logic         in_fire;
  logic         cap_main;
  logic         commit;
  logic         replay;
  logic         match;
  logic [W-1:0] opa_q, opb_q;
  logic [1:0]   age_q;
  logic [P-1:0] core_p, main_q, shadow_d;

  mulvl_hold #(.W(W), .ZERO_THRESH(ZERO_THRESH)) u_hold (
    .mcand(op_a), .one_cycle(hold_one)
  );

  mulvl_core #(.W(W), .AGED_ZEROS(AGED_ZEROS)) u_core (
    .clk(clk), .rst_n(rst_n), .launch(in_fire), .restart(replay),
    .launch_a(op_a), .launch_b(op_b),
    .opa_q(opa_q), .opb_q(opb_q), .age_q(age_q), .core_p(core_p)
  );

  mulvl_razor #(.P(P)) u_razor (
    .clk(clk), .rst_n(rst_n), .cap_main(cap_main), .core_p(core_p),
    .main_q(main_q), .shadow_d(shadow_d), .match(match)
  );

  assign commit   = (state_q == ST_SHADOW) && match;
  assign replay   = (state_q == ST_SHADOW) && !match;
  assign in_ready = (state_q == ST_IDLE) || commit;
  assign in_fire  = in_valid && in_ready;
  assign cap_main = (state_q == ST_RUN) && (two_q ? (age_q == 2'd1) : (age_q == 2'd0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      two_q      <= 1'b0;
      out_valid  <= 1'b0;
      out_prod   <= '0;
      replay_err <= 1'b0;
      cnt_done   <= '0;
      cnt_long   <= '0;
      cnt_replay <= '0;
    end else begin
      out_valid  <= 1'b0;
      replay_err <= 1'b0;
      if (cap_main) state_q <= ST_SHADOW;
      if (commit) begin
        out_valid <= 1'b1;
        out_prod  <= main_q;
        cnt_done  <= cnt_done + 1'b1;
        state_q   <= ST_IDLE;
      end
      if (replay) begin
        replay_err <= 1'b1;
        two_q      <= 1'b1;
        cnt_replay <= cnt_replay + 1'b1;
        state_q    <= ST_RUN;
      end
      if (in_fire) begin
        two_q   <= !hold_one;
        state_q <= ST_RUN;
        if (!hold_one) cnt_long <= cnt_long + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mulvl_check.sv
module mulvl_check #(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           hold_one,
  input logic           commit,
  input logic [W-1:0]   opa_q,
  input logic [W-1:0]   opb_q,
  input logic [2*W-1:0] main_q,
  input logic           out_valid,
  input logic           replay_err,
  input logic [CNT_W-1:0] cnt_done,
  input logic [CNT_W-1:0] cnt_replay
);
  logic [2*W-1:0] ref_p;
  logic           acc;
  assign ref_p = {{W{1'b0}}, opa_q} * {{W{1'b0}}, opb_q};
  assign acc   = in_valid && in_ready;

  p_commit_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (main_q == ref_p));

  p_short_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hold_one) |=> ##1 !out_valid ##1 (out_valid || replay_err));

  p_long_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hold_one) |=> ##1 (!out_valid && !replay_err) ##1 (!out_valid && !replay_err)
                           ##1 (out_valid && !replay_err));

  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  p_replay_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    replay_err |=> !out_valid ##1 !out_valid ##1 out_valid);

  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, replay_err}));

  p_done_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_done == $past(cnt_done) + 1'b1));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(cnt_done));

  p_replay_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    replay_err |-> (cnt_replay == $past(cnt_replay) + 1'b1));
endmodule

bind mulvl_top mulvl_check #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .hold_one(hold_one), .commit(commit), .opa_q(opa_q), .opb_q(opb_q),
  .main_q(main_q), .out_valid(out_valid), .replay_err(replay_err),
  .cnt_done(cnt_done), .cnt_replay(cnt_replay)
);

// File: tb/sim_mulvl_top.sv
`timescale 1ns/1ps
module sim_mulvl_top;
  localparam int W = 8;
  localparam int P = 2 * W;
  localparam int THR = 4;
  localparam int AGED = 6;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic in_ready, out_valid, replay_err;
  logic [P-1:0] out_prod;
  logic [CW-1:0] cnt_done, cnt_long, cnt_replay;

  always #4 clk = ~clk;

  mulvl_top #(.W(W), .ZERO_THRESH(THR), .AGED_ZEROS(AGED), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_prod(out_prod),
    .replay_err(replay_err), .cnt_done(cnt_done), .cnt_long(cnt_long),
    .cnt_replay(cnt_replay)
  );

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  int n_ops = 0, n_long = 0, n_rep = 0;
  logic [P-1:0] q_prod[$];
  int q_cyc[$];
  string q_tag[$];
  int q_err[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge; leaves at a falling edge.
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
    int z, lat;
    string tag;
    z = W - $countones(a);
    if (z < THR) begin lat = 3; tag = "R4"; n_long++; end
    else if (z < AGED) begin lat = 5; tag = "R6"; n_rep++; end
    else begin lat = 2; tag = "R3"; end
    op_a = a; op_b = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q_prod.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
    q_cyc.push_back(cyc + 1 + lat);
    q_tag.push_back(tag);
    if (lat == 5) q_err.push_back(cyc + 3);
    n_ops++;
    @(negedge clk);
    check(in_ready == 1'b0, "R5", in_ready, 0);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      check(!(out_valid && replay_err), "R7", {out_valid, replay_err}, 0);
      if (out_valid) begin
        if (q_prod.size() == 0) check(1'b0, "R7", 1, 0);
        else begin
          logic [P-1:0] ep;
          int ec;
          string et;
          ep = q_prod.pop_front(); ec = q_cyc.pop_front(); et = q_tag.pop_front();
          check(out_prod == ep, "R2", out_prod, ep);
          check(cyc == ec, et, cyc, ec);
        end
      end
      if (replay_err) begin
        if (q_err.size() == 0) check(1'b0, "R6", 1, 0);
        else begin
          int ee;
          ee = q_err.pop_front();
          check(cyc == ee, "R6", cyc, ee);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(replay_err == 1'b0, "R1", replay_err, 0);
    check(cnt_done == 0 && cnt_long == 0 && cnt_replay == 0, "R1",
          cnt_done + cnt_long + cnt_replay, 0);

    // Directed: one-cycle (zeros >= 6), two-cycle (zeros < 4), replay (zeros 4..5)
    send(8'h00, 8'hFF);   // 8 zeros, R3
    send(8'h01, 8'hFF);   // 7 zeros
    send(8'hC0, 8'h37);   // 6 zeros, boundary of AGED
    send(8'hFF, 8'hFF);   // 0 zeros, R4 max product
    send(8'hF8, 8'h00);   // 3 zeros, boundary below THR
    send(8'h0F, 8'hAB);   // 4 zeros, R6 replay at THR
    send(8'h07, 8'h99);   // 5 zeros, R6
    send(8'hFE, 8'h80);
    repeat (6) @(negedge clk);
    send(8'h3C, 8'hFF);   // after idle gap
    send(8'h10, 8'h10);

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[7:0] & (i[0] ? 8'hFF : lfsr[15:8]), lfsr[15:8]);
      if (i % 37 == 0) repeat (3) @(negedge clk);
    end

    begin
      int guard = 0;
      while (q_prod.size() != 0 && guard < 50) begin @(negedge clk); guard++; end
    end
    repeat (2) @(negedge clk);
    check(q_prod.size() == 0, "R7", q_prod.size(), 0);
    check(q_err.size() == 0, "R6", q_err.size(), 0);
    check(cnt_done == CW'(n_ops), "R8", cnt_done, n_ops);
    check(cnt_long == CW'(n_long), "R8", cnt_long, n_long);
    check(cnt_replay == CW'(n_rep), "R8", cnt_replay, n_rep);
    check(in_ready == 1'b1, "R5", in_ready, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule